// File: doc/BRIEF.md
# Two-Mode Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A burst-start strobe captures a full address and an ordering mode. An internal two-bit beat counter starts at zero. Each advance strobe moves the burst on by one beat.

The two low address bits for the current beat come from the captured low bits and the beat count, in one of two orders:
- **Interleaved:** the low bits are the captured low bits XOR the beat count.
- **Linear:** the low bits are the captured low bits plus the beat count, modulo four.

The upper address bits come straight from the captured address. A flag marks the fourth beat of the burst.

The block sits beside a burst-capable memory controller. The controller drives the start strobe together with the first address, then one advance per transferred beat. It reads the beat address and the last-beat flag back from this block. When no strobe is present, the block holds its output. If the controller advances past the fourth beat, the counter wraps and the same four-address sequence repeats.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_o` is all zeros and `last_o` is low.
- R2: A cycle with `start_i` high captures `addr_i`. From the next cycle `addr_o` equals that address. The bits of `addr_o` above bit 1 stay at the captured upper bits until the next start.
- R3: With `mode_i` low at start (linear), the low bits are (start + beat) mod 4. A start of 01 gives 01, 10, 11, 00 on successive advances.
- R4: With `mode_i` high at start (interleaved), the low bits are start XOR beat. Start 01 gives 01, 00, 11, 10. Start 10 gives 10, 11, 00, 01. Start 11 gives 11, 10, 01, 00.
- R5: A burst that starts at 00 gives 00, 01, 10, 11 in both modes.
- R6: In a cycle with neither `start_i` nor `adv_i` high, `addr_o` and `last_o` do not change on the next cycle.
- R7: When `start_i` and `adv_i` are high in the same cycle, the start wins. The burst restarts at beat 0 with the new address, and no beat is skipped.
- R8: `last_o` is high exactly while the beat count is 3, which is the fourth beat. A start clears it.
- R9: An advance on the fourth beat wraps the beat count to 0. `addr_o` returns to the starting address and the sequence repeats.
- R10: `mode_i` is sampled only in a start cycle. Changing it during a burst has no effect on the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst-start strobe; captures `addr_i` and `mode_i` |
| adv_i | input | 1 | Advance strobe; moves to the next beat |
| mode_i | input | 1 | Ordering: 1 = interleaved (XOR), 0 = linear (mod-4 add) |
| addr_i | input | ADDR_W | Starting address of the burst |
| addr_o | output | ADDR_W | Address of the current beat |
| last_o | output | 1 | High on the fourth beat |

## Verification
The bench walks every starting offset in both orders and checks each beat against a value it computes itself. Three behaviours get dedicated scenarios:
- **Mixing up the orders.** A design that swaps XOR for addition only differs from the correct one at unaligned starts such as 01, where the beats would come out as 01, 10, 11, 00 instead of 01, 00, 11, 10.
- **Start colliding with advance.** When both strobes arrive together, a design that lets the advance win would begin the new burst on beat 1.
- **Mode toggled mid-burst.** A design that reads `mode_i` live instead of latching it at start would change order partway through the burst.

A further scenario advances past the fourth beat. A counter that saturates instead of wrapping would leave `last_o` stuck high and never return to the starting address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned LOW_W = 2;
  typedef logic [LOW_W-1:0] low_t;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Low address bits for a given beat of a burst
  function automatic low_t beat_low(low_t base, low_t beat, order_e ord);
    low_t r;
    if (ord == ORD_INTERLEAVE) r = base ^ beat;
    else                       r = low_t'(base + beat);
    return r;
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  output low_t beat_o,
  output logic last_o
);
  localparam low_t BEAT_MAX = {LOW_W{1'b1}};

  low_t beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (clear_i) beat_q <= '0;
    else if (step_i)  beat_q <= low_t'(beat_q + 1'b1);
  end

  assign beat_o = beat_q;
  assign last_o = (beat_q == BEAT_MAX);
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] base_o,
  output order_e            ord_o
);
  logic [ADDR_W-1:0] base_q;
  order_e            ord_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ord_q  <= ORD_LINEAR;
    end else if (load_i) begin
      base_q <= addr_i;
      ord_q  <= order_e'(mode_i);
    end
  end

  assign base_o = base_q;
  assign ord_o  = ord_q;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int unsigned UP_W = ADDR_W - LOW_W;

  // Named internal events for the checker
  logic              burst_load;
  logic              beat_step;
  low_t              beat_cnt;
  logic [ADDR_W-1:0] base_addr;
  order_e            burst_ord;
  low_t              low_now;

  assign burst_load = start_i;
  assign beat_step  = adv_i & ~start_i;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (burst_load),
    .addr_i (addr_i),
    .mode_i (mode_i),
    .base_o (base_addr),
    .ord_o  (burst_ord)
  );

  burst_beat_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (burst_load),
    .step_i  (beat_step),
    .beat_o  (beat_cnt),
    .last_o  (last_o)
  );

  assign low_now = beat_low(base_addr[LOW_W-1:0], beat_cnt, burst_ord);

  generate
    if (UP_W > 0) begin : g_upper
      assign addr_o = {base_addr[ADDR_W-1:LOW_W], low_now};
    end else begin : g_low_only
      assign addr_o = low_now;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_o,
  input low_t              beat,
  input logic              step
);
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_state: assert (addr_o == '0 && !last_o && beat == '0)
        else $error("reset state wrong");
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> addr_o == $past(addr_i));

  a_r2_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> addr_o[ADDR_W-1:LOW_W] == $past(addr_o[ADDR_W-1:LOW_W]));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> beat == low_t'($past(beat) + 1'b1));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !adv_i) |=> ($stable(addr_o) && $stable(last_o)));

  a_r7_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && adv_i) |=> beat == '0);

  a_r8_last_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !last_o);

  a_r8_last_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_o) |-> $past(step));

  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_o) |=> (beat == '0 && !last_o));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .adv_i   (adv_i),
  .addr_i  (addr_i),
  .addr_o  (addr_o),
  .last_o  (last_o),
  .beat    (beat_cnt),
  .step    (beat_step)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  localparam int unsigned ADDR_W = 16;
  localparam real HALF = 4.0;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              adv_i = 1'b0;
  logic              mode_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic              last_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(HALF) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .adv_i(adv_i),
    .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o), .last_o(last_o)
  );

  // Expected low bits, worked out per bit and by integer arithmetic
  function automatic logic [1:0] exp_low(int s, int b, bit inter);
    logic [1:0] r;
    if (inter) begin
      r[1] = ((s / 2) % 2) != ((b / 2) % 2);
      r[0] = (s % 2) != (b % 2);
    end else begin
      r = 2'((s + b) % 4);
    end
    return r;
  endfunction

  task automatic chk(string req, logic [ADDR_W-1:0] exp_a, logic exp_l);
    checks++;
    if (addr_o !== exp_a || last_o !== exp_l) begin
      fails++;
      $display("FAIL %s: addr_o=%h last_o=%b expected addr_o=%h last_o=%b",
               req, addr_o, last_o, exp_a, exp_l);
    end
  endtask

  // One clock: drive at negedge, release after posedge, sample mid-cycle
  task automatic cyc(logic s, logic a, logic m, logic [ADDR_W-1:0] ad);
    @(negedge clk);
    start_i = s; adv_i = a; mode_i = m; addr_i = ad;
    @(posedge clk);
    #2;
    start_i = 1'b0; adv_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", '0, 1'b0);
  endtask

  // Full burst, comparing each beat with the computed order
  task automatic t_burst(string req, logic [ADDR_W-1:0] a, bit inter);
    logic [ADDR_W-1:0] e;
    cyc(1'b1, 1'b0, inter, a);
    for (int b = 0; b < 4; b++) begin
      e = {a[ADDR_W-1:2], exp_low(int'(a[1:0]), b, inter)};
      chk(req, e, b == 3);
      if (b < 3) cyc(1'b0, 1'b1, 1'b0, '0);
    end
  endtask

  // Stated sequences written out literally
  task automatic t_literal(string req, logic [1:0] s, bit inter,
                           logic [1:0] q0, logic [1:0] q1,
                           logic [1:0] q2, logic [1:0] q3);
    logic [1:0] q [4];
    q = '{q0, q1, q2, q3};
    cyc(1'b1, 1'b0, inter, {14'h2a5c, s});
    for (int b = 0; b < 4; b++) begin
      chk(req, {14'h2a5c, q[b]}, b == 3);
      if (b < 3) cyc(1'b0, 1'b1, 1'b0, '0);
    end
  endtask

  task automatic t_hold();
    cyc(1'b1, 1'b0, 1'b0, 16'h1231);
    cyc(1'b0, 1'b1, 1'b0, '0);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b0, 1'b1, 16'hffff);
      chk("R6", 16'h1232, 1'b0);
    end
  endtask

  task automatic t_priority();
    cyc(1'b1, 1'b0, 1'b0, 16'h0040);
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R8", 16'h0043, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 16'hbee1);
    chk("R7", 16'hbee1, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R7", 16'hbee0, 1'b0);
  endtask

  task automatic t_wrap();
    cyc(1'b1, 1'b0, 1'b1, 16'h7772);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R8", 16'h7771, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R9", 16'h7772, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R9", 16'h7773, 1'b0);
  endtask

  task automatic t_mode_latch();
    cyc(1'b1, 1'b0, 1'b1, 16'h0101);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R10", 16'h0100, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R10", 16'h0103, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 16'h0101);
    cyc(1'b0, 1'b1, 1'b1, '0);
    chk("R10", 16'h0102, 1'b0);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_literal("R3", 2'b01, 1'b0, 2'b01, 2'b10, 2'b11, 2'b00);
    t_literal("R4", 2'b01, 1'b1, 2'b01, 2'b00, 2'b11, 2'b10);
    t_literal("R4", 2'b10, 1'b1, 2'b10, 2'b11, 2'b00, 2'b01);
    t_literal("R4", 2'b11, 1'b1, 2'b11, 2'b10, 2'b01, 2'b00);
    t_literal("R5", 2'b00, 1'b0, 2'b00, 2'b01, 2'b10, 2'b11);
    t_literal("R5", 2'b00, 1'b1, 2'b00, 2'b01, 2'b10, 2'b11);
    for (int s = 0; s < 4; s++) begin
      t_burst("R3", {14'h1357, 2'(s)}, 1'b0);
      t_burst("R4", {14'h0f0f, 2'(s)}, 1'b1);
    end
    t_burst("R2", 16'hdead, 1'b0);
    t_hold();
    t_priority();
    t_wrap();
    t_mode_latch();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule